// File: doc/BRIEF.md
# Multi-Lane Serial Slave Front-End

This block is the pin-side front end of a serial memory slave. It watches the serial clock, the active-low chip select and four bidirectional data pins. It turns the serial stream into whole bytes for a command decoder, and it turns bytes from that decoder back into a serial stream. Data can move one, two or four bits per clock. The decoder owns the protocol. For each phase it tells the front end two things: whether the phase is an input or an output phase, and how many lanes that phase uses.

All pins are oversampled on a system clock that runs at least four times faster than the serial clock. Each pin passes through a two-flop synchronizer. The block accepts either clock idle level, high or low. It captures input bits on rising serial-clock edges and launches output bits on falling edges.

In one- and two-lane phases, the fourth pin works as an active-low pause input. In four-lane phases that pin carries data instead. After reset, the block stays deaf until it has seen a chip-select falling edge.

Top module: `spi_mio_slave`

## Requirements
- R1: Both clock idle levels are accepted. With the clock idling low or idling high at the chip-select falling edge, input bits are captured on rising clock edges only.
- R2: In an input phase with `lane_sel` = 0 (one lane), one bit is taken from IO0 on each rising edge, most significant bit first. After the eighth bit, `rx_byte` holds the byte and `rx_valid` pulses for one system clock.
- R3: In an input phase with `lane_sel` = 2 (four lanes), one nibble is taken per rising edge, high nibble first, with IO3 carrying the nibble's top bit. In an input phase, `lane_sel` = 1 (two lanes) is treated as one lane on IO0.
- R4: In an output phase with one lane, the falling edge that starts a byte loads `tx_byte` and pulses `tx_load`. IO1 then presents bit 7 first, and each later falling edge moves to the next lower bit. `io_oe` is 4'b0010.
- R5: In an output phase with `lane_sel` = 1, each falling edge presents a bit pair, most significant pair first, with the higher bit on IO1 and the lower on IO0. `io_oe` is 4'b0011.
- R6: In an output phase with `lane_sel` = 2, each falling edge presents a nibble, high nibble first, on IO3..IO0. `io_oe` is 4'b1111.
- R7: Chip select going high discards any partial byte and clears the bit position. `io_oe` goes to 0 within two system clocks.
- R8: After reset, no clock edge has any effect and `io_oe` stays 0 until a chip-select falling edge has been seen. This holds even if chip select was already low during reset.
- R9: In one- or two-lane phases, IO3 low while selected pauses the block. `io_oe` is 0, clock edges and data are ignored, and shifting resumes at the same bit once IO3 returns high.
- R10: In four-lane phases, IO3 low does not pause the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Active-low chip select pin |
| io_in | input | 4 | Input values of IO3..IO0 |
| lane_sel | input | 2 | Lanes for the current phase: 0 one, 1 two, 2 four |
| dir_out | input | 1 | 1 when the current phase drives data out |
| tx_byte | input | 8 | Next byte to send, supplied by the decoder |
| rx_byte | output | 8 | Last assembled input byte |
| rx_valid | output | 1 | One-clock strobe: `rx_byte` is new |
| tx_load | output | 1 | One-clock strobe: `tx_byte` was taken |
| io_out | output | 4 | Output values for IO3..IO0 |
| io_oe | output | 4 | Per-pin output enables for IO3..IO0 |

## Verification
A pin change reaches the edge detector after two synchronizer flops. The register it drives (`rx_valid`, `rx_byte`, `tx_load`, the output shifter and the bit position) updates on the third system-clock edge after the change. A combinational output enable follows chip select or the pause pin two edges after the change. The bench holds every serial clock level for six system clocks and samples at falling system-clock edges only after that hold, so each result has settled before it is read. Strobes are counted by a monitor process, so a missing or duplicated pulse shows up as a count mismatch.

// File: rtl/spi_mio_slave.sv
module spi_mio_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [3:0] io_in,
  input  logic [1:0] lane_sel,
  input  logic       dir_out,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       tx_load,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);

  logic [1:0] sck_q, cs_q;
  logic       sck_d, cs_d;
  logic [3:0] io_q1, io_q2;
  logic       armed;
  logic [2:0] bcnt;
  logic [7:0] rx_sh, tx_sh;

  logic       cs_s, sck_s, x4, active, held, run, rise, fall;
  logic [2:0] step_in, step_out, cnt_in;
  logic [7:0] rx_next;

  assign cs_s   = cs_q[1];
  assign sck_s  = sck_q[1];
  assign x4     = lane_sel[1];
  assign active = armed & ~cs_s;
  assign held   = active & ~x4 & ~io_q2[3];
  assign run    = active & ~held;
  assign rise   = run & sck_s & ~sck_d;
  assign fall   = run & ~sck_s & sck_d;

  assign step_in  = x4 ? 3'd4 : 3'd1;
  assign step_out = x4 ? 3'd4 : (lane_sel[0] ? 3'd2 : 3'd1);
  assign cnt_in   = bcnt + step_in;
  assign rx_next  = x4 ? {rx_sh[3:0], io_q2} : {rx_sh[6:0], io_q2[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 2'b00;
      sck_d <= 1'b0;
      cs_q  <= 2'b00;
      cs_d  <= 1'b0;
      io_q1 <= 4'hF;
      io_q2 <= 4'hF;
      armed <= 1'b0;
    end else begin
      sck_q <= {sck_q[0], sck};
      sck_d <= sck_s;
      cs_q  <= {cs_q[0], cs_n};
      cs_d  <= cs_s;
      io_q1 <= io_in;
      io_q2 <= io_q1;
      if (~cs_s & cs_d) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt     <= 3'd0;
      rx_sh    <= 8'h00;
      tx_sh    <= 8'h00;
      rx_byte  <= 8'h00;
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (!active) begin
        bcnt <= 3'd0;
      end else if (rise && !dir_out) begin
        rx_sh <= rx_next;
        bcnt  <= cnt_in;
        if (cnt_in == 3'd0) begin
          rx_byte  <= rx_next;
          rx_valid <= 1'b1;
        end
      end else if (fall && dir_out) begin
        if (bcnt == 3'd0) begin
          tx_sh   <= tx_byte;
          tx_load <= 1'b1;
        end else begin
          tx_sh <= x4 ? {tx_sh[3:0], 4'h0} :
                   (lane_sel[0] ? {tx_sh[5:0], 2'b00} : {tx_sh[6:0], 1'b0});
        end
        bcnt <= bcnt + step_out;
      end
    end
  end

  assign io_oe  = (run && dir_out) ? (x4 ? 4'hF : (lane_sel[0] ? 4'h3 : 4'h2)) : 4'h0;
  assign io_out = x4 ? tx_sh[7:4] :
                  (lane_sel[0] ? {2'b00, tx_sh[7:6]} : {2'b00, tx_sh[7], 1'b0});

  assert_rx_only_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(!dir_out));
  assert_tx_only_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(dir_out));
  assert_oe_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'h2) || (io_oe == 4'h3) || (io_oe == 4'hF));
  assert_cs_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bcnt == 3'd0));
  assert_unarmed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!rx_valid && !tx_load && io_oe == 4'h0));
  assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> ($stable(bcnt) && $stable(tx_sh) && !rx_valid && !tx_load));

endmodule

// File: tb/spi_mio_slave_bench.sv
module spi_mio_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b0;
  logic [3:0] io_drv = 4'hF;
  logic [1:0] lane_sel = 2'd0;
  logic       dir_out = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic       rx_valid, tx_load;
  logic [3:0] io_out, io_oe;

  int checks = 0, fails = 0, rx_cnt = 0, tx_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mio_slave u_spi_mio_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_drv),
    .lane_sel(lane_sel), .dir_out(dir_out), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_load(tx_load),
    .io_out(io_out), .io_oe(io_oe));

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_byte; end
    if (tx_load) tx_cnt <= tx_cnt + 1;
  end

  function automatic logic [3:0] exp_oe(input int lane);
    return (lane == 2) ? 4'hF : (lane == 1) ? 4'h3 : 4'h2;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic beat_in(input logic [3:0] d);
    sck = 1'b0; io_drv = d; wait_clk(HP);
    sck = 1'b1; wait_clk(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, input int lane);
    if (lane == 2) begin
      beat_in(b[7:4]); beat_in(b[3:0]);
    end else begin
      for (int i = 7; i >= 0; i--) beat_in({3'b111, b[i]});
    end
    io_drv = 4'hF;
  endtask

  task automatic recv_beats(input int lane, input int n, inout logic [7:0] got, inout bit oe_ok);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; wait_clk(HP);
      if (io_oe != exp_oe(lane)) oe_ok = 1'b0;
      if (lane == 2) got = {got[3:0], io_out};
      else if (lane == 1) got = {got[5:0], io_out[1:0]};
      else got = {got[6:0], io_out[1]};
      sck = 1'b1; wait_clk(HP);
    end
  endtask

  task automatic start_txn(input bit mode3);
    sck = mode3; io_drv = 4'hF; wait_clk(HP);
    cs_n = 1'b0; wait_clk(HP);
  endtask

  task automatic end_txn(input bit mode3);
    cs_n = 1'b1; wait_clk(HP);
    sck = mode3; wait_clk(HP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] got, b, t, t2;
    int rc, tc, lin, lout;
    bit m3, ok;
    void'($urandom(32'd4711));

    wait_clk(5); rst_n = 1'b1; wait_clk(4);
    chk(io_oe == 4'h0 && rx_cnt == 0, "reset R8", io_oe, 0);

    // R8: cs low since reset, edges must do nothing
    dir_out = 1'b0; send_byte(8'hA5, 0);
    chk(rx_cnt == 0, "R8 no accept before cs fall", rx_cnt, 0);
    dir_out = 1'b1; sck = 1'b0; wait_clk(HP);
    chk(io_oe == 4'h0 && tx_cnt == 0, "R8 no output before cs fall", io_oe, 0);
    sck = 1'b1; wait_clk(HP); dir_out = 1'b0;
    end_txn(1'b0);

    // R1/R2 mode 0, one lane
    start_txn(1'b0); send_byte(8'h96, 0);
    chk(rx_cnt == 1 && rx_last == 8'h96, "R2 x1 input mode0", rx_last, 8'h96);
    end_txn(1'b0);

    // R1 mode 3
    start_txn(1'b1); send_byte(8'h3C, 0);
    chk(rx_cnt == 2 && rx_last == 8'h3C, "R1 x1 input mode3", rx_last, 8'h3C);
    end_txn(1'b1);

    // R3 x4 and x2-as-x1 input; R10 IO3 low in x4
    start_txn(1'b0); lane_sel = 2'd2; send_byte(8'h35, 2);
    chk(rx_cnt == 3 && rx_last == 8'h35, "R3 x4 input", rx_last, 8'h35);
    send_byte(8'h07, 2);
    chk(rx_cnt == 4 && rx_last == 8'h07, "R10 IO3 low no pause in x4", rx_last, 8'h07);
    lane_sel = 2'd1; send_byte(8'hC1, 0);
    chk(rx_cnt == 5 && rx_last == 8'hC1, "R3 x2 input treated as x1", rx_last, 8'hC1);
    end_txn(1'b0);

    // R7 partial byte discarded
    start_txn(1'b0); lane_sel = 2'd0;
    for (int i = 0; i < 5; i++) beat_in(4'hF);
    end_txn(1'b0); start_txn(1'b0);
    send_byte(8'h5A, 0);
    chk(rx_cnt == 6 && rx_last == 8'h5A, "R7 partial byte dropped", rx_last, 8'h5A);
    end_txn(1'b0);

    // R9 pause in input phase
    start_txn(1'b0); b = 8'hB4;
    for (int i = 7; i >= 4; i--) beat_in({3'b111, b[i]});
    beat_in(4'b0110); beat_in(4'b0111);
    chk(rx_cnt == 6, "R9 edges ignored while paused", rx_cnt, 6);
    io_drv = 4'hF; wait_clk(HP);
    for (int i = 3; i >= 0; i--) beat_in({3'b111, b[i]});
    chk(rx_cnt == 7 && rx_last == 8'hB4, "R9 resume input", rx_last, 8'hB4);
    end_txn(1'b0);

    // R9 pause in output phase, R4
    start_txn(1'b1); dir_out = 1'b1; lane_sel = 2'd0; tx_byte = 8'hE2;
    got = 0; ok = 1; tc = tx_cnt;
    recv_beats(0, 3, got, ok);
    io_drv = 4'h7; wait_clk(HP);
    chk(io_oe == 4'h0, "R9 oe off while paused", io_oe, 0);
    sck = 1'b0; wait_clk(HP); sck = 1'b1; wait_clk(HP);
    io_drv = 4'hF; wait_clk(HP);
    recv_beats(0, 5, got, ok);
    chk(got == 8'hE2 && ok, "R9 R4 resume output", got, 8'hE2);
    chk(tx_cnt == tc + 1, "R4 one tx_load per byte", tx_cnt - tc, 1);
    // R7 oe drops on cs high mid byte
    recv_beats(0, 2, got, ok);
    cs_n = 1'b1; wait_clk(3);
    chk(io_oe == 4'h0, "R7 oe off after cs high", io_oe, 0);
    dir_out = 1'b0; end_txn(1'b1);

    // random transactions covering R1 R4 R5 R6
    for (int k = 0; k < 20; k++) begin
      m3 = $urandom_range(0, 1);
      lin = $urandom_range(0, 2);
      lout = $urandom_range(0, 2);
      b = $urandom; t = $urandom; t2 = $urandom;
      start_txn(m3);
      dir_out = 1'b0; lane_sel = lin[1:0]; rc = rx_cnt;
      send_byte(b, (lin == 2) ? 2 : 0);
      chk(rx_cnt == rc + 1 && rx_last == b, "R1 R2 R3 random input", rx_last, b);
      dir_out = 1'b1; lane_sel = lout[1:0]; tx_byte = t; tc = tx_cnt;
      got = 0; ok = 1;
      recv_beats(lout, (lout == 2) ? 2 : (lout == 1) ? 4 : 8, got, ok);
      tx_byte = t2;
      chk(got == t && ok, (lout == 2) ? "R6 x4 output" : (lout == 1) ? "R5 x2 output" : "R4 x1 output", got, t);
      got = 0;
      recv_beats(lout, (lout == 2) ? 2 : (lout == 1) ? 4 : 8, got, ok);
      chk(got == t2 && tx_cnt == tc + 2, "R4 R5 R6 second byte", got, t2);
      dir_out = 1'b0;
      end_txn(m3);
    end

    report();
  end
endmodule